// File: doc/BRIEF.md
# External Interrupt and Wake Unit

This unit watches three dedicated external interrupt pins and ten capture inputs and turns their activity into interrupt requests. Each dedicated pin can be set for edge or level detection, and its polarity bit picks rising or falling edge, or high or low level. Every source has a pending flag. Software reads these flags over a simple address/data register bus and clears edge flags by writing a one to them. The unit drives one interrupt line per dedicated pin, one combined line for all capture sources, and a wake request for the power controller.

A wake request comes only from dedicated pins whose wake-enable bit is set. Detection is asynchronous, so it works while the clock is stopped. The event is held until the clock runs again, and then it is registered into the pin's pending flag. Capture inputs can never wake the device. Every input passes through a two-stage synchronizer before any clocked detection.

Register map (4-bit word address, 16-bit data). Bit i of a dedicated-pin register belongs to pin i.
- 0: mode. 1 = edge, 0 = level.
- 1: polarity. 1 = rising/high, 0 = falling/low.
- 2: wake enable.
- 3: capture enable, bit j for capture input j.
- 4: dedicated pending flags, write one to clear.
- 5: capture pending flags, write one to clear.

Top module: `eiw_top`

## Requirements
- R1: After reset, ext_irq, cap_irq and wake_req are 0. Address 0 reads 0x7 (all edge). Address 1 reads 0x7 (all rising/high). Addresses 2 and 3 read 0.
- R2: In edge mode, a transition to the active level sets the pin's flag. Active level means high when the polarity bit is 1 and low when it is 0. ext_irq[i] rises on the third rising clock edge after the pin changes, and not before.
- R3: An edge flag stays set after the pin returns to idle. Writing 1 to bit i of address 4 clears it. Writing 0 leaves it unchanged.
- R4: In level mode, the flag follows the pin's active level with the same three-edge delay. Writing 1 to address 4 has no effect on it.
- R5: If an edge set and a write-one clear of the same flag land on the same clock edge, the flag ends up set.
- R6: A rising edge on cap_pin[j] sets bit j of address 5 only while bit j of address 3 is 1, with the same three-edge delay. Disabled inputs and falling edges are ignored. cap_irq is the OR of the address-5 flags. Writing 1 to a bit of address 5 clears that flag.
- R7: wake_req rises without any clock once a dedicated pin whose bit in address 2 is 1 reaches its active level. It stays high after the pin returns to idle. A pin whose wake bit is 0 never raises it.
- R8: Capture inputs never assert wake_req, whatever their enables or the wake-enable bits.
- R9: When the clock restarts, a held wake event on an edge-mode pin sets that pin's flag by the third clock edge, even if the pulse ended while the clock was stopped. Writing 1 to that flag then also drops wake_req, provided the pin is idle.
- R10: Addresses 0 to 3 read back the last value written, masked to their width. Addresses 6 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, may be stopped in low-power modes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 3 | Dedicated external interrupt pins (asynchronous) |
| cap_pin | input | 10 | Capture inputs used as interrupt sources (asynchronous) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational from bus_addr) |
| ext_irq | output | 3 | Per-pin interrupt request (pending flag) |
| cap_irq | output | 1 | Combined capture interrupt request |
| wake_req | output | 1 | Wake request to the power controller |

## Verification
Two functions can meet on the same clock edge. One is a pin edge reaching the pending register. The other is a software write-one clear of that same flag. The bench first sets a flag. It then raises the pin again and times the clear write so that its strobe is sampled on the third edge after the pin change, which is the edge where the new event lands. The flag must read back as set. A second collision comes from stopping the clock: pins and capture inputs are pulsed with no clock running, and only the enabled dedicated pins may raise the wake request. Once the clock restarts, the held event must appear as a pending flag.

// File: rtl/eiw_pkg.sv
package eiw_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_MODE     = 4'd0;
  localparam logic [ADDR_W-1:0] A_POL      = 4'd1;
  localparam logic [ADDR_W-1:0] A_WAKE     = 4'd2;
  localparam logic [ADDR_W-1:0] A_CAP_EN   = 4'd3;
  localparam logic [ADDR_W-1:0] A_EXT_PEND = 4'd4;
  localparam logic [ADDR_W-1:0] A_CAP_PEND = 4'd5;
endpackage

// File: rtl/eiw_sync.sv
module eiw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[s] <= '0;
      else        st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/eiw_ext_chan.sv
module eiw_ext_chan #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  input  logic edge_mode,
  input  logic pol_high,
  input  logic wake_en,
  input  logic clr,
  output logic pend,
  output logic wake_lat
);
  logic pin_s, act_s, act_prev, edge_evt;
  logic trig, lat_s, lat_prev, lat_rise, set_evt;

  // clocked path
  eiw_sync #(.W(1), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_s)
  );

  assign act_s    = pol_high ? pin_s : ~pin_s;
  assign edge_evt = act_s & ~act_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_prev <= 1'b0;
    else        act_prev <= act_s;
  end

  // asynchronous wake capture, works with the clock stopped
  assign trig = wake_en & (pol_high ? pin_raw : ~pin_raw);

  always_ff @(posedge clk or posedge trig or negedge rst_n) begin
    if (!rst_n)    wake_lat <= 1'b0;
    else if (trig) wake_lat <= 1'b1;
    else if (clr)  wake_lat <= 1'b0;
  end

  eiw_sync #(.W(1), .STAGES(SYNC_STAGES)) u_lat_sync (
    .clk(clk), .rst_n(rst_n), .d(wake_lat), .q(lat_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_prev <= 1'b0;
    else        lat_prev <= lat_s;
  end

  assign lat_rise = lat_s & ~lat_prev;
  assign set_evt  = edge_evt | lat_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend <= 1'b0;
    else if (edge_mode) begin
      if (set_evt)       pend <= 1'b1;
      else if (clr)      pend <= 1'b0;
    end else             pend <= act_s;
  end

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && set_evt && clr) |=> pend);
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && clr && !set_evt) |=> !pend);
  p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && pend && !clr) |=> pend);
endmodule

// File: rtl/eiw_cap_bank.sv
module eiw_cap_bank #(
  parameter int NCAP        = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCAP-1:0] cap_raw,
  input  logic [NCAP-1:0] cap_en,
  input  logic [NCAP-1:0] clr,
  output logic [NCAP-1:0] pend
);
  logic [NCAP-1:0] cap_s, cap_prev;

  eiw_sync #(.W(NCAP), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cap_raw), .q(cap_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_prev <= '0;
    else        cap_prev <= cap_s;
  end

  for (genvar j = 0; j < NCAP; j++) begin : g_cap
    logic rise;
    assign rise = cap_s[j] & ~cap_prev[j] & cap_en[j];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend[j] <= 1'b0;
      else if (rise)   pend[j] <= 1'b1;
      else if (clr[j]) pend[j] <= 1'b0;
    end

    p_cap_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_en[j] && !pend[j]) |=> !pend[j]);
  end
endmodule

// File: rtl/eiw_regs.sv
module eiw_regs
  import eiw_pkg::*;
#(
  parameter int NEXT   = 3,
  parameter int NCAP   = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NEXT-1:0]   ext_pend,
  input  logic [NCAP-1:0]   cap_pend,
  output logic [NEXT-1:0]   ext_mode,
  output logic [NEXT-1:0]   ext_pol,
  output logic [NEXT-1:0]   ext_wake,
  output logic [NCAP-1:0]   cap_en,
  output logic [NEXT-1:0]   ext_clr,
  output logic [NCAP-1:0]   cap_clr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_mode <= '1;
      ext_pol  <= '1;
      ext_wake <= '0;
      cap_en   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MODE:   ext_mode <= bus_wdata[NEXT-1:0];
        A_POL:    ext_pol  <= bus_wdata[NEXT-1:0];
        A_WAKE:   ext_wake <= bus_wdata[NEXT-1:0];
        A_CAP_EN: cap_en   <= bus_wdata[NCAP-1:0];
        default: ;
      endcase
    end
  end

  assign ext_clr = (bus_wr && bus_addr == A_EXT_PEND) ? bus_wdata[NEXT-1:0] : '0;
  assign cap_clr = (bus_wr && bus_addr == A_CAP_PEND) ? bus_wdata[NCAP-1:0] : '0;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE:     bus_rdata[NEXT-1:0] = ext_mode;
      A_POL:      bus_rdata[NEXT-1:0] = ext_pol;
      A_WAKE:     bus_rdata[NEXT-1:0] = ext_wake;
      A_CAP_EN:   bus_rdata[NCAP-1:0] = cap_en;
      A_EXT_PEND: bus_rdata[NEXT-1:0] = ext_pend;
      A_CAP_PEND: bus_rdata[NCAP-1:0] = cap_pend;
      default:    bus_rdata = '0;
    endcase
  end

  p_cfg_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MODE) |=> (ext_mode == $past(bus_wdata[NEXT-1:0])));
endmodule

// File: rtl/eiw_top.sv
module eiw_top
  import eiw_pkg::*;
#(
  parameter int NEXT        = 3,
  parameter int NCAP        = 10,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEXT-1:0]   ext_pin,
  input  logic [NCAP-1:0]   cap_pin,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NEXT-1:0]   ext_irq,
  output logic              cap_irq,
  output logic              wake_req
);
  logic [NEXT-1:0] ext_mode, ext_pol, ext_wake, ext_clr, ext_pend, wake_lat;
  logic [NCAP-1:0] cap_en, cap_clr, cap_pend;

  eiw_regs #(.NEXT(NEXT), .NCAP(NCAP), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_pend(ext_pend), .cap_pend(cap_pend),
    .ext_mode(ext_mode), .ext_pol(ext_pol), .ext_wake(ext_wake),
    .cap_en(cap_en), .ext_clr(ext_clr), .cap_clr(cap_clr)
  );

  for (genvar i = 0; i < NEXT; i++) begin : g_ext
    eiw_ext_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk(clk), .rst_n(rst_n), .pin_raw(ext_pin[i]),
      .edge_mode(ext_mode[i]), .pol_high(ext_pol[i]), .wake_en(ext_wake[i]),
      .clr(ext_clr[i]), .pend(ext_pend[i]), .wake_lat(wake_lat[i])
    );
  end

  eiw_cap_bank #(.NCAP(NCAP), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_raw(cap_pin), .cap_en(cap_en),
    .clr(cap_clr), .pend(cap_pend)
  );

  assign ext_irq  = ext_pend;
  assign cap_irq  = |cap_pend;
  assign wake_req = |wake_lat;

  p_wake_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_wake == '0 && !wake_req) |=> (!wake_req || $past(ext_wake) != ext_wake || bus_wr));
endmodule

// File: tb/tb_eiw_top.sv
module tb_eiw_top;
  logic        clk = 1'b0, clk_run = 1'b1, rst_n = 1'b0;
  logic [2:0]  ext_pin = '0;
  logic [9:0]  cap_pin = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  ext_irq;
  logic        cap_irq, wake_req;
  int          errors = 0, checks = 0;

  eiw_top dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .cap_pin(cap_pin),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ext_irq(ext_irq), .cap_irq(cap_irq),
    .wake_req(wake_req)
  );

  always begin
    #5;
    if (clk_run) clk = ~clk;
  end

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [2:0] exp_ext(logic [2:0] m, logic [2:0] p, logic [2:0] n);
    logic [2:0] r;
    for (int i = 0; i < 3; i++)
      r[i] = m[i] ? (p[i] & n[i]) : (p[i] ? n[i] : ~n[i]);
    return r;
  endfunction

  initial begin
    logic [15:0] d;
    void'($urandom(32'h1cafe));
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    #1;
    chk("R1 ext_irq", ext_irq, 0);
    chk("R1 cap_irq", cap_irq, 0);
    chk("R1 wake_req", wake_req, 0);
    rd(4'd0, d); chk("R1 mode", d, 16'h7);
    rd(4'd1, d); chk("R1 pol", d, 16'h7);
    rd(4'd2, d); chk("R1 wake", d, 0);
    rd(4'd3, d); chk("R1 capen", d, 0);

    // R2 edge latency on pin 0
    tick(1);
    ext_pin[0] = 1'b1;
    tick(2); #1; chk("R2 not before third edge", ext_irq, 0);
    tick(1); #1; chk("R2 set on third edge", ext_irq, 3'b001);

    // R3 hold after idle, write 0 no effect, write 1 clears
    tick(1);
    ext_pin[0] = 1'b0;
    tick(4); #1; chk("R3 holds", ext_irq, 3'b001);
    tick(1); wr(4'd4, 16'h0); #1; chk("R3 write0", ext_irq, 3'b001);
    tick(1); wr(4'd4, 16'h1); #1; chk("R3 w1c", ext_irq, 3'b000);

    // R5 set and clear on same edge
    tick(1);
    ext_pin[1] = 1'b1; tick(4); ext_pin[1] = 1'b0; tick(4);
    #1; chk("R5 pre", ext_irq, 3'b010);
    tick(1);
    ext_pin[1] = 1'b1;
    tick(2);
    wr(4'd4, 16'h2);
    #1; chk("R5 set wins", ext_irq, 3'b010);
    ext_pin[1] = 1'b0; tick(4); wr(4'd4, 16'h2); #1;
    chk("R5 later clear", ext_irq, 3'b000);

    // R2 falling edge polarity, pin 2
    tick(1);
    wr(4'd1, 16'h3); tick(4); wr(4'd4, 16'h7); tick(1);
    ext_pin[2] = 1'b1; tick(4); #1; chk("R2 rise ignored pol low", ext_irq, 0);
    tick(1); ext_pin[2] = 1'b0; tick(4); #1; chk("R2 falling edge", ext_irq, 3'b100);
    tick(1); wr(4'd1, 16'h7); tick(4); wr(4'd4, 16'h7); #1;
    chk("R2 cleanup", ext_irq, 0);

    // R4 level mode pin 0 high active
    tick(1);
    wr(4'd0, 16'h6); tick(1);
    ext_pin[0] = 1'b1; tick(3); #1; chk("R4 level high", ext_irq, 3'b001);
    tick(1); wr(4'd4, 16'h1); tick(1); #1; chk("R4 w1c no effect", ext_irq, 3'b001);
    ext_pin[0] = 1'b0; tick(3); #1; chk("R4 follows low", ext_irq, 0);
    tick(1); wr(4'd0, 16'h7); tick(4); wr(4'd4, 16'h7);

    // R6 capture
    tick(1);
    wr(4'd3, 16'h005);
    cap_pin = 10'h00f; tick(3); #1;
    rd(4'd5, d); chk("R6 enabled rises only", d, 16'h005);
    chk("R6 cap_irq", cap_irq, 1);
    tick(1); cap_pin = '0; tick(4);
    rd(4'd5, d); chk("R6 fall ignored", d, 16'h005);
    tick(1); wr(4'd5, 16'h001); #1; rd(4'd5, d); chk("R6 w1c partial", d, 16'h004);
    tick(1); wr(4'd5, 16'h3ff); #1; chk("R6 cap_irq clear", cap_irq, 0);

    // R8 capture never wakes, with clock running and stopped
    tick(1);
    wr(4'd2, 16'h7); wr(4'd3, 16'h3ff);
    cap_pin = 10'h3ff; tick(4); #1; chk("R8 running", wake_req, 0);
    cap_pin = '0; tick(4);
    clk_run = 1'b0; #20;
    cap_pin = 10'h2aa; #3; chk("R8 stopped", wake_req, 0);
    cap_pin = '0; #3;
    clk_run = 1'b1;
    tick(1); wr(4'd5, 16'h3ff); wr(4'd3, 16'h0);

    // R7 asynchronous wake, R9 restart registration
    wr(4'd2, 16'h1);
    clk_run = 1'b0; #20;
    ext_pin[1] = 1'b1; #3; chk("R7 disabled pin", wake_req, 0);
    ext_pin[1] = 1'b0; #3;
    ext_pin[0] = 1'b1; #3; chk("R7 async wake", wake_req, 1);
    ext_pin[0] = 1'b0; #3; chk("R7 held", wake_req, 1);
    chk("R9 not yet pending", ext_irq, 0);
    clk_run = 1'b1;
    tick(3); #1; chk("R9 pending after restart", ext_irq, 3'b001);
    tick(1); wr(4'd4, 16'h1); #1;
    chk("R9 wake dropped", wake_req, 0);
    chk("R9 flag cleared", ext_irq, 0);
    tick(4); #1; chk("R9 stays cleared", ext_irq, 0);
    wr(4'd2, 16'h0);

    // R10 readback and unmapped
    wr(4'd3, 16'hffff); rd(4'd3, d); chk("R10 capen mask", d, 16'h3ff);
    wr(4'd0, 16'hfff5); rd(4'd0, d); chk("R10 mode mask", d, 16'h5);
    wr(4'd0, 16'h7); wr(4'd3, 16'h0);
    for (int a = 6; a < 16; a++) begin
      rd(a[3:0], d); chk("R10 unmapped", d, 0);
    end
    tick(4); wr(4'd4, 16'h7); wr(4'd5, 16'h3ff);

    // random capture trials (R6)
    for (int t = 0; t < 20; t++) begin
      logic [9:0] en, pat;
      en = 10'($urandom); pat = 10'($urandom);
      wr(4'd3, {6'd0, en});
      cap_pin = pat; tick(4);
      rd(4'd5, d); chk("R6 random pend", d, {6'd0, pat & en});
      chk("R6 random irq", cap_irq, |(pat & en));
      cap_pin = '0; tick(4);
      wr(4'd5, 16'h3ff); #1; chk("R6 random clear", cap_irq, 0);
    end

    // random dedicated-pin trials (R2, R4)
    for (int t = 0; t < 20; t++) begin
      logic [2:0] m, p, n;
      m = 3'($urandom); p = 3'($urandom); n = 3'($urandom);
      ext_pin = '0;
      wr(4'd0, {13'd0, m}); wr(4'd1, {13'd0, p});
      tick(4); wr(4'd4, 16'h7); tick(1);
      ext_pin = n; tick(4);
      rd(4'd4, d); chk("R2/R4 random pend", d, {13'd0, exp_ext(m, p, n)});
      chk("R4 random irq", ext_irq, exp_ext(m, p, n));
      ext_pin = '0;
      wr(4'd0, 16'h7); wr(4'd1, 16'h7); tick(4); wr(4'd4, 16'h7);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule